// File: doc/BRIEF.md
# Flow-Table Settling Emulator

This block is a clocked stand-in for a one-bit asynchronous state machine. The machine is described by a next-state flow table over two inputs. One input clears the state and the other sets it. When neither is high the state holds. When both are high the next state is the complement of the present state, so that input combination has no resting point. Each clock edge stands for one propagation step: the stored state takes the table's next-state value.

For the present state and inputs, the block reports combinationally whether that table entry is stable (the next state equals the present state) or transient. It raises an oscillation flag once the state has kept flipping under unchanged inputs. The flag is meant for stepping through input sequences, for example a walk over the input combinations in Gray order, and for showing where a design would never settle. A synchronous reset returns the state to zero and clears the oscillation history.

Top module: `flow_settle`

## Requirements
- R1: With drive_lo=0 and drive_hi=0, q keeps its value across the clock edge.
- R2: With drive_lo=1 and drive_hi=0, q is 0 after the next clock edge.
- R3: With drive_lo=0 and drive_hi=1, q is 1 after the next clock edge.
- R4: With drive_lo=1 and drive_hi=1, q inverts on every clock edge.
- R5: stable is 1 exactly when the table's next state equals q for the present inputs; transient is always the inverse of stable. Both follow the inputs without a clock.
- R6: osc goes to 1 once two consecutive clock edges have each been transient steps under the same input pair, and that pair is still applied. With both inputs held at 1 from a stable start, osc is 1 after the second edge.
- R7: osc is 0 whenever the input pair differs from the pair sampled at the last clock edge, and 0 after any edge that was not a transient step.
- R8: A clock edge with rst=1 sets q to 0 and clears the oscillation history, whatever the inputs are, so osc is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each rising edge is one settling step |
| rst | input | 1 | Synchronous reset, active high |
| drive_lo | input | 1 | Clear input (forces state to 0 when alone) |
| drive_hi | input | 1 | Set input (forces state to 1 when alone) |
| q | output | 1 | Current emulated state |
| stable | output | 1 | Present table entry is a resting point |
| transient | output | 1 | Present table entry will change the state |
| osc | output | 1 | Oscillation detected under unchanged inputs |

## Verification
The stable and transient outputs follow a change of inputs in the same cycle. The state q answers one rising edge after the inputs are applied. The osc output rises after the second transient edge under a held input pair and falls in the same cycle as an input change. The driver applies each input pair just after a falling edge and queues the values expected for that cycle. The monitor samples 2 ns later, so every comparison sees the state left by the last rising edge together with the newly applied inputs. Reset is checked directly once it is released, with inputs that would otherwise have moved the state.

// File: rtl/flow_settle.sv
module flow_settle (
  input  logic clk,
  input  logic rst,
  input  logic drive_lo,
  input  logic drive_hi,
  output logic q,
  output logic stable,
  output logic transient,
  output logic osc
);

  logic [1:0] cur_in;
  logic [1:0] held_in;
  logic [1:0] run;
  logic       nxt;
  logic       same_in;

  assign cur_in  = {drive_lo, drive_hi};
  assign same_in = (cur_in == held_in);

  always_comb begin
    case (cur_in)
      2'b00:   nxt = q;
      2'b10:   nxt = 1'b0;
      2'b01:   nxt = 1'b1;
      default: nxt = ~q;
    endcase
  end

  assign stable    = (nxt == q);
  assign transient = ~stable;
  assign osc       = run[1] & same_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      q       <= 1'b0;
      held_in <= 2'b00;
      run     <= 2'd0;
    end else begin
      q       <= nxt;
      held_in <= cur_in;
      if (!transient)
        run <= 2'd0;
      else if (same_in && run != 2'd0)
        run <= 2'd2;
      else
        run <= 2'd1;
    end
  end

endmodule

module flow_settle_chk (
  input logic clk,
  input logic rst,
  input logic drive_lo,
  input logic drive_hi,
  input logic q,
  input logic stable,
  input logic transient,
  input logic osc
);

  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    (!drive_lo && !drive_hi) |=> (q == $past(q)));

  a_r2_clear: assert property (@(posedge clk) disable iff (rst)
    (drive_lo && !drive_hi) |=> !q);

  a_r3_set: assert property (@(posedge clk) disable iff (rst)
    (!drive_lo && drive_hi) |=> q);

  a_r4_flip: assert property (@(posedge clk) disable iff (rst)
    (drive_lo && drive_hi) |=> (q != $past(q)));

  a_r5_excl: assert property (@(posedge clk) disable iff (rst)
    stable != transient);

  a_r6_detect: assert property (@(posedge clk) disable iff (rst)
    (drive_lo && drive_hi) ##1 (drive_lo && drive_hi) ##1 (drive_lo && drive_hi) |-> osc);

  a_r7_inchg: assert property (@(posedge clk) disable iff (rst)
    ({drive_lo, drive_hi} != $past({drive_lo, drive_hi})) |-> !osc);

  a_r8_reset: assert property (@(posedge clk)
    rst |=> (!q && !osc));

endmodule

bind flow_settle flow_settle_chk u_chk (.*);

// File: tb/sim_flow_settle.sv
module sim_flow_settle;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic drive_lo = 1'b0;
  logic drive_hi = 1'b0;
  logic q, stable, transient, osc;

  always #5 clk = ~clk;

  flow_settle u0 (.clk(clk), .rst(rst), .drive_lo(drive_lo), .drive_hi(drive_hi),
                  .q(q), .stable(stable), .transient(transient), .osc(osc));

  typedef struct {
    logic  q;
    logic  st;
    logic  osc;
    string tag;
  } exp_t;

  exp_t sb[$];
  int   total = 0;
  int   fails = 0;
  bit   done  = 0;

  logic       m_q;
  logic [1:0] m_held;
  int         m_run;

  task automatic chk(input string tag, input logic got, input logic exp, input string what);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
    end
  endtask

  task automatic step(input logic lo, input logic hi);
    logic [1:0] in;
    logic nx;
    logic tr;
    exp_t e;
    @(negedge clk);
    drive_lo = lo;
    drive_hi = hi;
    in = {lo, hi};
    case (in)
      2'b00: begin nx = m_q;  e.tag = "R1 R5"; end
      2'b10: begin nx = 1'b0; e.tag = "R2 R5"; end
      2'b01: begin nx = 1'b1; e.tag = "R3 R5"; end
      default: begin nx = ~m_q; e.tag = "R4 R5 R6"; end
    endcase
    if (in != m_held) e.tag = {e.tag, " R7"};
    tr    = (nx != m_q);
    e.q   = m_q;
    e.st  = ~tr;
    e.osc = (m_run >= 2) && (in == m_held);
    sb.push_back(e);
    if (!tr) m_run = 0;
    else if (in == m_held && m_run != 0) m_run = 2;
    else m_run = 1;
    m_held = in;
    m_q    = nx;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    drive_lo = 1'b1;
    drive_hi = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    drive_lo = 1'b0;
    drive_hi = 1'b0;
    m_q = 1'b0; m_held = 2'b00; m_run = 0;
    #2;
    chk("R8", q, 1'b0, "q after reset");
    chk("R8", osc, 1'b0, "osc after reset");
    chk("R8 R5", stable, 1'b1, "stable after reset");
    chk("R5", transient, 1'b0, "transient after reset");
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, q, e.q, "q");
        chk(e.tag, stable, e.st, "stable");
        chk(e.tag, transient, ~e.st, "transient");
        chk(e.tag, osc, e.osc, "osc");
      end
    end
  end

  initial begin
    do_reset();
    step(0,0); step(0,0);
    step(0,1); step(0,1);
    step(0,0); step(0,0);
    step(1,0); step(1,0);
    step(0,0);
    // Gray-order walk
    step(0,1); step(1,1); step(1,1); step(1,1); step(1,1);
    step(1,0); step(1,0); step(0,0);
    // oscillation then release to set
    step(1,1); step(1,1); step(1,1); step(0,1); step(0,1);
    // oscillation then release to clear
    step(1,1); step(1,1); step(1,1); step(1,1); step(1,0); step(0,0);
    // oscillation interrupted by reset
    step(1,1); step(1,1); step(1,1);
    @(negedge clk);
    do_reset();
    step(1,1); step(1,1); step(1,1); step(0,0); step(0,0);
    @(negedge clk);
    @(negedge clk);
    if (sb.size() != 0) begin
      total++; fails++;
      $display("FAIL R5: got %0d pending items expected 0", sb.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule